// File: doc/BRIEF.md
# Multiframe Phase Counter with SYSREF Reload

This block keeps the local multiframe phase on the receive side of a deterministic-latency serial link. A counter advances once per link clock and wraps at a programmable multiframe length. Each wrap marks a multiframe boundary, and the block raises a one-cycle pulse on that cycle. Downstream logic uses these boundaries to release lane data together.

The SYSREF input is first captured in a register. A rising edge of that captured value loads the counter two link cycles later. The counter does not clear to zero. It takes a programmable phase value instead. Loading a non-zero phase moves every later boundary by a known number of cycles, which gives slow lanes time to arrive before the release point.

A mask input blocks further SYSREF events once alignment is done. An offset that does not fit the current length is clamped to the last count.

Top module: `mf_phase_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and boundary_o is 0.
- R2: With no reload pending, count_o rises by one each clock. When it is at or above mf_len_m1_i, it returns to 0 on the next clock. The multiframe length is mf_len_m1_i + 1 link clocks.
- R3: boundary_o is high in exactly those cycles in which count_o has just become 0, whether by wrap or by reload. It stays low during reset.
- R4: Suppose sysref_i is captured high at rising clock edge k and was captured low at edge k-1. Then count_o keeps counting freely through edge k+1 and shows the reload value from edge k+2 on.
- R5: The reload value is phase_off_i. With a length of 8, an offset of 0 gives a boundary at the reload cycle itself. An offset of 5 gives the first boundary 3 cycles later.
- R6: If phase_off_i is greater than mf_len_m1_i, the reload value is mf_len_m1_i.
- R7: Only a low-to-high change of the captured SYSREF triggers a reload. Holding sysref_i high causes no further reloads.
- R8: While sysref_mask_i is high, sysref_i edges cause no reload, and count_o keeps counting freely.
- R9: With mf_len_m1_i = 0, count_o stays 0 and boundary_o is high every cycle once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sysref_i | input | 1 | SYSREF, already in the link clock domain |
| sysref_mask_i | input | 1 | When high, SYSREF edges are ignored |
| mf_len_m1_i | input | CNT_W | Multiframe length minus one |
| phase_off_i | input | CNT_W | Value loaded into the counter on a SYSREF reload |
| count_o | output | CNT_W | Current multiframe count |
| boundary_o | output | 1 | One-cycle pulse when the count becomes 0 |

## Verification
The bench drives inputs on the falling edge and reads outputs on later falling edges, so it counts latency in whole clocks.

A SYSREF level driven before rising edge k is captured at k. The reload value then appears after edge k+2, three falling edges after the drive. Each reload test therefore checks the free-running value at the second falling edge and the offset at the third. Wrap and boundary results follow one clock per step from there.

For masked and held-high SYSREF, the bench predicts the free-running count, cycle by cycle, from a count value it reads first.

// File: rtl/mfpc_pkg.sv
package mfpc_pkg;
  // next-state selection for the phase counter
  typedef enum logic [1:0] {
    NXT_STEP = 2'd0,
    NXT_WRAP = 2'd1,
    NXT_LOAD = 2'd2
  } nxt_e;
endpackage

// File: rtl/sysref_capture.sv
module sysref_capture #(
  parameter int unsigned RELOAD_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sysref_i,
  input  logic mask_i,
  output logic load_o
);
  localparam int unsigned STAGES = (RELOAD_DLY > 0) ? RELOAD_DLY - 1 : 0;

  logic samp_q, prev_q, edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= sysref_i;
      prev_q <= samp_q;
    end
  end

  assign edge_w = samp_q & ~prev_q & ~mask_i;

  generate
    if (STAGES == 0) begin : g_nodly
      assign load_o = edge_w;
    end else begin : g_dly
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else if (STAGES == 1) pipe_q <= edge_w;
        else pipe_q <= {pipe_q[STAGES-2:0], edge_w};
      end
      assign load_o = pipe_q[STAGES-1];
    end
  endgenerate

  // a rising edge cannot repeat on back-to-back cycles
  assert_single_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  // a masked captured edge never yields a load on the next cycle
  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STAGES == 1 && mask_i) |=> !load_o);
endmodule

// File: rtl/offset_clamp.sv
module offset_clamp #(
  parameter int unsigned CNT_W = 5
) (
  input  logic [CNT_W-1:0] off_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic [CNT_W-1:0] off_o
);
  assign off_o = (off_i > len_m1_i) ? len_m1_i : off_i;

  always_comb begin
    assert_clamp_R6: assert (off_o <= len_m1_i);
  end
endmodule

// File: rtl/phase_count.sv
module phase_count
  import mfpc_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bnd_o
);
  nxt_e             sel;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bnd_q;

  always_comb begin
    if (load_i)                 sel = NXT_LOAD;
    else if (cnt_q >= len_m1_i) sel = NXT_WRAP;
    else                        sel = NXT_STEP;
    case (sel)
      NXT_LOAD: cnt_d = load_val_i;
      NXT_WRAP: cnt_d = '0;
      default:  cnt_d = cnt_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bnd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bnd_q <= (cnt_d == '0);
    end
  end

  assign cnt_o = cnt_q;
  assign bnd_o = bnd_q;

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q >= len_m1_i) |=> (cnt_q == '0));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q < len_m1_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_bnd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_q |-> (cnt_q == '0));
endmodule

// File: rtl/mf_phase_counter.sv
module mf_phase_counter #(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned RELOAD_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sysref_i,
  input  logic             sysref_mask_i,
  input  logic [CNT_W-1:0] mf_len_m1_i,
  input  logic [CNT_W-1:0] phase_off_i,
  output logic [CNT_W-1:0] count_o,
  output logic             boundary_o
);
  logic             load;
  logic [CNT_W-1:0] off_clamped;

  sysref_capture #(.RELOAD_DLY(RELOAD_DLY)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sysref_i(sysref_i),
    .mask_i  (sysref_mask_i),
    .load_o  (load)
  );

  offset_clamp #(.CNT_W(CNT_W)) u_clamp (
    .off_i   (phase_off_i),
    .len_m1_i(mf_len_m1_i),
    .off_o   (off_clamped)
  );

  phase_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(off_clamped),
    .len_m1_i  (mf_len_m1_i),
    .cnt_o     (count_o),
    .bnd_o     (boundary_o)
  );

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (count_o == $past(off_clamped)));
  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !boundary_o));
endmodule

// File: tb/mf_phase_counter_tb.sv
module mf_phase_counter_tb;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sysref = 1'b0;
  logic             mask = 1'b0;
  logic [CNT_W-1:0] len_m1 = 5'd7;
  logic [CNT_W-1:0] off = 5'd0;
  logic [CNT_W-1:0] count;
  logic             boundary;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  mf_phase_counter #(.CNT_W(CNT_W)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sysref_i     (sysref),
    .sysref_mask_i(mask),
    .mf_len_m1_i  (len_m1),
    .phase_off_i  (off),
    .count_o      (count),
    .boundary_o   (boundary)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    sysref = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 boundary", boundary, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_freerun();
    int c0;
    len_m1 = 5'd7;
    @(negedge clk);
    c0 = count;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R2 step/wrap", count, (c0 + k) % 8);
      chk("R3 boundary", boundary, ((c0 + k) % 8 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_reload0();
    int c0;
    len_m1 = 5'd7; off = 5'd0;
    @(negedge clk);
    c0 = count;
    sysref = 1'b1;
    @(negedge clk); sysref = 1'b0;
    @(negedge clk);
    chk("R4 not yet reloaded", count, (c0 + 2) % 8);
    @(negedge clk);
    chk("R4 reload offset 0", count, 0);
    chk("R3 R5 boundary on reload", boundary, 1);
    @(negedge clk);
    chk("R2 after reload", count, 1);
    chk("R3 boundary low", boundary, 0);
    settle();
  endtask

  task automatic t_offset5();
    len_m1 = 5'd7; off = 5'd5;
    @(negedge clk);
    sysref = 1'b1;
    @(negedge clk); sysref = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 reload offset 5", count, 5);
    chk("R5 no boundary at 5", boundary, 0);
    repeat (2) @(negedge clk);
    chk("R5 count 7", count, 7);
    chk("R5 boundary low", boundary, 0);
    @(negedge clk);
    chk("R5 boundary 3 later", boundary, 1);
    chk("R5 count wrapped", count, 0);
    settle();
  endtask

  task automatic t_held();
    len_m1 = 5'd7; off = 5'd2;
    @(negedge clk);
    sysref = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 first reload", count, 2);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk("R7 held high no reload", count, (2 + k) % 8);
    end
    settle();
  endtask

  task automatic t_mask();
    int c0;
    len_m1 = 5'd7; off = 5'd4; mask = 1'b1;
    @(negedge clk);
    c0 = count;
    sysref = 1'b1;
    @(negedge clk); sysref = 1'b0;
    chk("R8 masked", count, (c0 + 1) % 8);
    for (int k = 2; k <= 7; k++) begin
      @(negedge clk);
      chk("R8 masked", count, (c0 + k) % 8);
    end
    settle();
    mask = 1'b0;
  endtask

  task automatic t_clamp();
    len_m1 = 5'd3; off = 5'd9;
    @(negedge clk);
    sysref = 1'b1;
    @(negedge clk); sysref = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 clamped reload", count, 3);
    @(negedge clk);
    chk("R6 wrap at len 4", count, 0);
    chk("R3 boundary", boundary, 1);
    settle();
  endtask

  task automatic t_len1();
    len_m1 = 5'd0; off = 5'd0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 count", count, 0);
      chk("R9 boundary", boundary, 1);
    end
  endtask

  task automatic t_len32();
    len_m1 = 5'd31; off = 5'd31;
    @(negedge clk);
    sysref = 1'b1;
    @(negedge clk); sysref = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 reload 31", count, 31);
    chk("R3 boundary low", boundary, 0);
    @(negedge clk);
    chk("R2 wrap at 32", count, 0);
    chk("R3 boundary", boundary, 1);
    @(negedge clk);
    chk("R2 step", count, 1);
    settle();
  endtask

  initial begin
    t_reset();
    t_freerun();
    t_reload0();
    t_offset5();
    t_held();
    t_mask();
    t_clamp();
    t_len1();
    t_len32();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule